// File: doc/BRIEF.md
# Bouncing Up-Down Counter

This block is a free-running counter that climbs from zero to its all-ones value and then falls back to zero, over and over, so its output traces a triangle wave. No input chooses the counting direction. A one-bit direction register inside the block sets it. Each cycle, the next value of that register is worked out from the present count and the present direction.

The direction is itself a register, so its change takes effect one cycle late. The block therefore decides to turn around one step before each end value. It turns at one below the top while rising, and at one while falling. Because of this, the count reverses exactly at the ends. No end value repeats and none is overshot.

The default width is 4 bits, which gives the sequence 0, 1, …, 15, 14, …, 1, 0, 1, … with a period of 30 cycles. A synchronous active-high reset restarts the sequence at zero, counting upward. The direction is also driven out, registered, as a status output.

Top module: `bounce_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes 0 and `dir_down` becomes 0 after that edge. This holds for as long as `rst` stays high.
- R2: When `dir_down` is 0 (counting up) and `count` is below 15, the next `count` is `count` + 1.
- R3: When `dir_down` is 1 (counting down) and `count` is above 0, the next `count` is `count` − 1.
- R4: `dir_down` is 1 in every cycle where `count` equals 15. `dir_down` is 0 in every cycle where `count` equals 0. The direction changes on the same edge that moves the count onto an end value.
- R5: The value 15 is held for exactly one cycle and is followed by 14.
- R6: The value 0 is held for exactly one cycle while reset is low and is followed by 1. This includes the first cycle after reset is released.
- R7: The count never wraps. It never steps from 15 to 0 or from 0 to 15.
- R8: After reset is released, the pair (`count`, `dir_down`) repeats with a period of exactly 30 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| count | output | 4 | Registered counter value |
| dir_down | output | 1 | Registered direction: 1 while counting down, 0 while counting up |

## Verification
The main function is tried with three input patterns:
- **Two full periods after a clean reset.** This shows whether the turn happens exactly at 15 and 0. An early turn shows up as a repeated end value, and a late turn shows up as an overshoot or a wrap.
- **Reset applied at the top, with the direction already down.** This tells whether reset restores the upward direction or only clears the count.
- **Reset applied partway down, then held for several cycles.** This tells a real synchronous clear apart from a count that keeps moving under reset, and confirms the first step after release goes to 1.

// File: rtl/bounce_pkg.sv
package bounce_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

endpackage

// File: rtl/bounce_dir_ctrl.sv
module bounce_dir_ctrl
  import bounce_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] count,
  output dir_e             dir
);

  localparam logic [WIDTH-1:0] TOP_VAL   = '1;
  localparam logic [WIDTH-1:0] NEAR_TOP  = TOP_VAL - 1'b1;
  localparam logic [WIDTH-1:0] NEAR_BOT  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic turn;

  // Decide one step early: the new direction is used from the next cycle on.
  always_comb begin
    turn = ((dir == DIR_UP)   && (count == NEAR_TOP)) ||
           ((dir == DIR_DOWN) && (count == NEAR_BOT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir <= DIR_UP;
    end else if (turn) begin
      dir <= (dir == DIR_UP) ? DIR_DOWN : DIR_UP;
    end
  end

endmodule

// File: rtl/bounce_count_path.sv
module bounce_count_path
  import bounce_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  dir_e             dir,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;
  logic [WIDTH-1:0] next_val;

  always_comb begin
    inc_val  = count + 1'b1;
    dec_val  = count - 1'b1;
    next_val = (dir == DIR_DOWN) ? dec_val : inc_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      count <= next_val;
    end
  end

endmodule

// File: rtl/bounce_counter.sv
module bounce_counter
  import bounce_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count,
  output logic             dir_down
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  dir_e dir_q;

  bounce_dir_ctrl #(.WIDTH(WIDTH)) u_dir (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .dir   (dir_q)
  );

  bounce_count_path #(.WIDTH(WIDTH)) u_path (
    .clk   (clk),
    .rst   (rst),
    .dir   (dir_q),
    .count (count)
  );

  assign dir_down = (dir_q == DIR_DOWN);

  // R1: reset clears count and restores the upward direction
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == BOT_VAL) && !dir_down);

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && count != TOP_VAL) |=> count == $past(count) + 1'b1);

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (dir_down && count != BOT_VAL) |=> count == $past(count) - 1'b1);

  assert_top_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (count == TOP_VAL) |-> dir_down);

  assert_bottom_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (count == BOT_VAL) |-> !dir_down);

  assert_top_once_R5: assert property (@(posedge clk) disable iff (rst)
    (count == TOP_VAL) |=> count == TOP_VAL - 1'b1);

  assert_bottom_once_R6: assert property (@(posedge clk) disable iff (rst)
    (count == BOT_VAL) |=> count == BOT_VAL + 1'b1);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (count == TOP_VAL) |=> count != BOT_VAL);

endmodule

// File: tb/bounce_counter_tb_top.sv
module bounce_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_LEN = 30;

  // Expected {dir_down, count} for cycle i after reset release (i mod 30).
  localparam logic [4:0] EXP_VEC [PERIOD_LEN] = '{
    5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07,
    5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h1F,
    5'h1E, 5'h1D, 5'h1C, 5'h1B, 5'h1A, 5'h19, 5'h18, 5'h17,
    5'h16, 5'h15, 5'h14, 5'h13, 5'h12, 5'h11
  };

  logic       clk;
  logic       rst;
  logic [3:0] count;
  logic       dir_down;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  bounce_counter #(.WIDTH(4)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .dir_down (dir_down)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [3:0] exp_c, input logic exp_d);
    n_checks++;
    if (count !== exp_c || dir_down !== exp_d) begin
      n_fails++;
      $display("FAIL %s: count=%0d dir_down=%0b expected count=%0d dir_down=%0b",
               req, count, dir_down, exp_c, exp_d);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [3:0] prev;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 4'd0, 1'b0);
    rst = 1'b0;
    prev = 4'd0;

    // Two full periods walked against the table (R2..R8)
    for (int i = 1; i <= 2*PERIOD_LEN; i++) begin
      @(negedge clk);
      check("R2/R3/R4/R5/R6/R8 sequence", EXP_VEC[i % PERIOD_LEN][3:0],
            EXP_VEC[i % PERIOD_LEN][4]);
      n_checks++;
      if ((prev == 4'd15 && count == 4'd0) || (prev == 4'd0 && count == 4'd15)) begin
        n_fails++;
        $display("FAIL R7 wrap: prev=%0d count=%0d expected no wrap", prev, count);
      end
      prev = count;
    end

    // Directed: reset while at the top with direction down (R1)
    repeat (15) @(negedge clk);
    check("R4 at top before reset", 4'd15, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset from top", 4'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 first step after reset", 4'd1, 1'b0);

    // Directed: reset partway down, held several cycles (R1)
    repeat (23) @(negedge clk);
    check("R3 down phase value", 4'd6, 1'b1);
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 reset held", 4'd0, 1'b0);
    end
    rst = 1'b0;
    @(negedge clk);
    check("R6 zero followed by one", 4'd1, 1'b0);
    @(negedge clk);
    check("R2 climb after reset", 4'd2, 1'b0);

    finish_run();
  end

endmodule